// File: doc/BRIEF.md
# Spike-Train Set Logic Unit

This unit evaluates Boolean logic on spike trains, one bit per clock where a 1 marks a spike in that cycle. A logic value is carried by a whole train rather than a level. A pseudo-random source produces two reference trains, one standing for High and one for Low. The two never spike in the same cycle. An operand is High when it follows the High reference train and Low when it follows the Low one. Because both logic values are non-empty trains, none of the results collapses to an all-zero signal.

Gates are built from a two-output set element. One output passes the coincident spikes of its two inputs. The other passes the spikes of the first input that have no partner on the second. The inverter keeps the universe train (High union Low) where the operand is silent. The AND gate merges three terms: the coincidence of both operands with High, and each operand taken with Low. Every gate is free of delay, so the result train appears in the same cycle as its operands.

A detector watches the result train. It declares the logic value at the first result spike that lines up with a reference. From then on, every later result spike is checked against that verdict. A spike that lines up with the opposite reference sets a sticky error flag.

Top module: `spk_logic_unit`

## Requirements
- R1: `ref_hi` and `ref_lo` never carry a spike in the same cycle, and both are 0 while `rst` is high and in the first cycle after it.
- R2: Both reference trains are non-empty: after reset, each spikes at least once within the first 64 cycles.
- R3: The gates add no delay: `y_train` follows the operand and reference values of the same cycle. With `op_and`=0, an all-ones `x1_train` gives an empty `y_train`, and an all-zero `x1_train` gives `y_train` equal to `ref_hi | ref_lo`.
- R4: With `op_and`=0 (inverter on `x1_train`), feeding the High train yields the Low train, and feeding the Low train yields the High train.
- R5: With `op_and`=1, `y_train` equals the High train when both `x1_train` and `x2_train` follow High, and equals the Low train for the other three combinations.
- R6: For any operand trains, `y_train` never spikes in a cycle where neither reference spikes.
- R7: `det_valid` is 0 until the first `y_train` spike that coincides with a reference, and goes to 1 combinationally in that same cycle. `det_high` is then 1 if that reference was High and 0 if it was Low. `det_high` reads 0 whenever `det_valid` is 0.
- R8: Once given, the verdict (`det_valid`=1 and the value of `det_high`) stays unchanged until a clear.
- R9: After a verdict, a `y_train` spike that coincides with the opposite reference sets `det_err` from the next cycle on. `det_err` stays set until a clear.
- R10: `det_clr` is synchronous. In its cycle `det_valid` and `det_high` read 0 and no spike is taken. From the next cycle, `det_err` is 0 and the detector waits for a new first spike.
- R11: `rst` restarts the pseudo-random source from its seed, so the reference sequence after every reset is identical, and it also clears the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_clr | input | 1 | Synchronous clear of the detector |
| op_and | input | 1 | 0: inverter on x1_train, 1: AND of x1_train and x2_train |
| x1_train | input | 1 | First operand spike train |
| x2_train | input | 1 | Second operand spike train |
| ref_hi | output | 1 | High reference train, registered |
| ref_lo | output | 1 | Low reference train, registered |
| y_train | output | 1 | Result spike train, same cycle as operands |
| det_valid | output | 1 | Verdict available |
| det_high | output | 1 | Verdict value: 1 High, 0 Low |
| det_err | output | 1 | Sticky error: a later spike contradicted the verdict |

## Verification
Some properties hold on every cycle, and embedded assertions watch them there:
- the reference trains stay disjoint and the generator state never reaches zero;
- the result never spikes outside the universe;
- a verdict, once taken, is never altered before a clear, and it only appears after a decisive spike;
- the error flag is sticky;
- a clear empties the detector.

Other behaviour depends on stimulus chosen over many cycles, and only the directed scenarios can show it:
- the truth of the inverter and of all four AND combinations;
- that each reference train eventually spikes;
- that a reset replays the same reference sequence;
- that a contradicting spike raises the error one cycle later.

// File: rtl/spk_pkg.sv
package spk_pkg;

  // Outcome of one reference cycle, chosen from two generator bits.
  typedef enum logic [1:0] {
    REF_NONE_A = 2'b00,
    REF_HIGH   = 2'b01,
    REF_LOW    = 2'b10,
    REF_NONE_B = 2'b11
  } ref_pick_t;

  typedef struct packed {
    logic hi;
    logic lo;
  } ref_pair_t;

  function automatic ref_pair_t decode_pick(input logic [1:0] bits);
    ref_pair_t r;
    r.hi = (ref_pick_t'(bits) == REF_HIGH);
    r.lo = (ref_pick_t'(bits) == REF_LOW);
    return r;
  endfunction

endpackage

// File: rtl/spk_ref_gen.sv
module spk_ref_gen
  import spk_pkg::*;
#(
  parameter int              LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  output logic ref_hi,
  output logic ref_lo
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_nx;
  ref_pair_t         pick;

  // Galois step: shift right, fold taps back in when the outgoing bit is 1.
  always_comb begin
    state_nx = state_q >> 1;
    if (state_q[0]) state_nx = state_nx ^ TAPS;
  end

  assign pick = decode_pick(state_q[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
      ref_hi  <= 1'b0;
      ref_lo  <= 1'b0;
    end else begin
      state_q <= state_nx;
      ref_hi  <= pick.hi;
      ref_lo  <= pick.lo;
    end
  end

  // R1: the two reference trains are disjoint on every cycle
  a_r1_refs_disjoint: assert property (@(posedge clk) disable iff (rst)
    !(ref_hi && ref_lo));

  // R11: generator never locks up in the all-zero state
  a_r11_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/spk_orthon.sv
module spk_orthon (
  input  logic a,
  input  logic b,
  output logic both,
  output logic a_only
);

  assign both   = a & b;
  assign a_only = a & ~b;

endmodule

// File: rtl/spk_gate.sv
module spk_gate #(
  parameter int N_IN = 2
) (
  input  logic            ref_hi,
  input  logic            ref_lo,
  input  logic            op_and,
  input  logic [N_IN-1:0] x_in,
  output logic            y
);

  logic            univ;
  logic            not_y;
  logic            pair_both;
  logic            pair_only_unused;
  logic            hi_term;
  logic            hi_only_unused;
  logic [N_IN-1:0] lo_term;
  logic [N_IN-1:0] lo_only_unused;
  logic            inv_both_unused;
  logic            and_y;

  assign univ = ref_hi | ref_lo;

  // Inverter: universe spikes where the operand is silent.
  spk_orthon u_inv (
    .a      (univ),
    .b      (x_in[0]),
    .both   (inv_both_unused),
    .a_only (not_y)
  );

  // AND, first branch: coincidence of both operands, then with High.
  spk_orthon u_pair (
    .a      (x_in[0]),
    .b      (x_in[1]),
    .both   (pair_both),
    .a_only (pair_only_unused)
  );

  spk_orthon u_hi (
    .a      (pair_both),
    .b      (ref_hi),
    .both   (hi_term),
    .a_only (hi_only_unused)
  );

  // AND, remaining branches: each operand with Low.
  for (genvar i = 0; i < N_IN; i++) begin : g_lo
    spk_orthon u_lo (
      .a      (x_in[i]),
      .b      (ref_lo),
      .both   (lo_term[i]),
      .a_only (lo_only_unused[i])
    );
  end

  // Output element: union of the excitatory branches.
  assign and_y = hi_term | (|lo_term);
  assign y     = op_and ? and_y : not_y;

endmodule

// File: rtl/spk_detector.sv
module spk_detector (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ref_hi,
  input  logic ref_lo,
  input  logic y,
  output logic valid,
  output logic high,
  output logic err
);

  logic valid_q;
  logic high_q;
  logic err_q;
  logic decisive;
  logic conflict;

  assign decisive = y & (ref_hi | ref_lo);
  assign conflict = valid_q & y & (high_q ? ref_lo : ref_hi);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_q <= 1'b0;
      high_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (!valid_q && decisive) begin
        valid_q <= 1'b1;
        high_q  <= ref_hi;
      end
      if (conflict) err_q <= 1'b1;
    end
  end

  assign valid = ~clr & (valid_q | decisive);
  assign high  = ~clr & (valid_q ? high_q : (decisive & ref_hi));
  assign err   = err_q;

  // R8: verdict held until a clear
  a_r8_verdict_held: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !clr) |=> (valid_q && (high_q == $past(high_q))));

  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr) |=> err_q);

  // R10: a clear empties the detector
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!valid_q && !err_q));

  // R7: a verdict only appears after a decisive spike
  a_r7_verdict_from_spike: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(y && (ref_hi || ref_lo)));

endmodule

// File: rtl/spk_logic_unit.sv
module spk_logic_unit #(
  parameter int                LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  input  logic det_clr,
  input  logic op_and,
  input  logic x1_train,
  input  logic x2_train,
  output logic ref_hi,
  output logic ref_lo,
  output logic y_train,
  output logic det_valid,
  output logic det_high,
  output logic det_err
);

  localparam int N_IN = 2;

  logic [N_IN-1:0] x_vec;

  assign x_vec = {x2_train, x1_train};

  spk_ref_gen #(
    .LFSR_W (LFSR_W),
    .TAPS   (TAPS),
    .SEED   (SEED)
  ) u_ref (
    .clk    (clk),
    .rst    (rst),
    .ref_hi (ref_hi),
    .ref_lo (ref_lo)
  );

  spk_gate #(
    .N_IN (N_IN)
  ) u_gate (
    .ref_hi (ref_hi),
    .ref_lo (ref_lo),
    .op_and (op_and),
    .x_in   (x_vec),
    .y      (y_train)
  );

  spk_detector u_det (
    .clk    (clk),
    .rst    (rst),
    .clr    (det_clr),
    .ref_hi (ref_hi),
    .ref_lo (ref_lo),
    .y      (y_train),
    .valid  (det_valid),
    .high   (det_high),
    .err    (det_err)
  );

  // R6: result stays inside the universe for any operands
  a_r6_inside_universe: assert property (@(posedge clk) disable iff (rst)
    y_train |-> (ref_hi || ref_lo));

endmodule

// File: tb/spk_logic_unit_test.sv
`timescale 1ns/1ps
module spk_logic_unit_test;

  // operand sources: 0 Low train, 1 High train, 2 all zero, 3 all one
  localparam int SRC_LO = 0, SRC_HI = 1, SRC_ZERO = 2, SRC_ONE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic det_clr = 1'b0;
  logic op_and = 1'b0;
  logic x1_train = 1'b0;
  logic x2_train = 1'b0;
  logic ref_hi, ref_lo, y_train, det_valid, det_high, det_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model of the detector, built from R7..R10
  bit mv, mh, me;

  always #2.5 clk = ~clk;

  spk_logic_unit uut (
    .clk(clk), .rst(rst), .det_clr(det_clr), .op_and(op_and),
    .x1_train(x1_train), .x2_train(x2_train),
    .ref_hi(ref_hi), .ref_lo(ref_lo), .y_train(y_train),
    .det_valid(det_valid), .det_high(det_high), .det_err(det_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic src_val(input int s, input logic h, input logic l);
    case (s)
      SRC_LO:   return l;
      SRC_HI:   return h;
      SRC_ZERO: return 1'b0;
      default:  return 1'b1;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; det_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mv = 0; mh = 0; me = 0;
  endtask

  // One cycle: drive operands from the current references, check y and the
  // detector outputs, then advance the model across the next edge.
  task automatic step(input int s1, input int s2, input bit and_op, input bit clr,
                      input string yreq);
    logic h, l, a, b, ye, dec, ev, eh;
    @(negedge clk);
    h = ref_hi; l = ref_lo;
    a = src_val(s1, h, l); b = src_val(s2, h, l);
    x1_train = a; x2_train = b; op_and = and_op; det_clr = clr;
    #0.5;
    if (and_op) ye = (a & b & h) | (a & l) | (b & l);
    else        ye = ~a & (h | l);
    chk(y_train === ye, yreq, y_train, ye);
    chk(!(y_train && !(h || l)), "R6", y_train, 0);
    dec = ye & (h | l);
    ev = ~clr & (mv | dec);
    eh = ~clr & (mv ? mh : (dec & h));
    chk(det_valid === ev, clr ? "R10" : "R7", det_valid, ev);
    chk(det_high === eh, mv ? "R8" : "R7", det_high, eh);
    chk(det_err === me, "R9", det_err, me);
    if (clr) begin mv = 0; mh = 0; me = 0; end
    else if (!mv && dec) begin mv = 1; mh = h; end
    else if (mv && ye && (mh ? l : h)) me = 1;
  endtask

  task automatic t_reset_state();
    do_reset();
    #0.5;
    chk(ref_hi === 1'b0 && ref_lo === 1'b0, "R1", {ref_hi, ref_lo}, 0);
    chk(det_valid === 1'b0, "R11", det_valid, 0);
    chk(det_err === 1'b0, "R11", det_err, 0);
  endtask

  task automatic t_refs();
    int nh = 0, nl = 0, both = 0;
    do_reset();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (ref_hi) nh++;
      if (ref_lo) nl++;
      if (ref_hi && ref_lo) both++;
    end
    chk(nh > 0, "R2", nh, 1);
    chk(nl > 0, "R2", nl, 1);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ref_hi && ref_lo) both++;
    end
    chk(both == 0, "R1", both, 0);
  endtask

  task automatic t_reseed();
    logic [1:0] seq [32];
    int diff = 0;
    do_reset();
    for (int i = 0; i < 32; i++) begin @(negedge clk); seq[i] = {ref_hi, ref_lo}; end
    do_reset();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if ({ref_hi, ref_lo} !== seq[i]) diff++;
    end
    chk(diff == 0, "R11", diff, 0);
  endtask

  task automatic t_not(input int s);
    do_reset();
    for (int i = 0; i < 80; i++) step(s, SRC_LO, 1'b0, 1'b0, "R4");
    chk(det_valid === 1'b1, "R7", det_valid, 1);
    chk(det_high === (s == SRC_LO), "R4", det_high, (s == SRC_LO));
  endtask

  task automatic t_flat();
    do_reset();
    for (int i = 0; i < 40; i++) step(SRC_ONE, SRC_LO, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 40; i++) step(SRC_ZERO, SRC_LO, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_and(input int s1, input int s2);
    do_reset();
    for (int i = 0; i < 80; i++) step(s1, s2, 1'b1, 1'b0, "R5");
    chk(det_high === (s1 == SRC_HI && s2 == SRC_HI), "R5", det_high,
        (s1 == SRC_HI && s2 == SRC_HI));
  endtask

  task automatic t_error_and_clear();
    do_reset();
    // inverter on High gives Low verdict, then flip operand to contradict
    for (int i = 0; i < 64; i++) step(SRC_HI, SRC_LO, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 64; i++) step(SRC_LO, SRC_LO, 1'b0, 1'b0, "R9");
    chk(det_err === 1'b1, "R9", det_err, 1);
    chk(det_high === 1'b0, "R8", det_high, 0);
    step(SRC_LO, SRC_LO, 1'b0, 1'b1, "R10");
    for (int i = 0; i < 64; i++) step(SRC_LO, SRC_LO, 1'b0, 1'b0, "R10");
    chk(det_err === 1'b0 && det_high === 1'b1, "R10", {det_err, det_high}, 1);
  endtask

  initial begin
    t_reset_state();
    t_refs();
    t_reseed();
    t_not(SRC_HI);
    t_not(SRC_LO);
    t_flat();
    t_and(SRC_LO, SRC_LO);
    t_and(SRC_LO, SRC_HI);
    t_and(SRC_HI, SRC_LO);
    t_and(SRC_HI, SRC_HI);
    t_error_and_clear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule